// File: doc/BRIEF.md
# Alarm Comparator and Interrupt Flag Register

This block sits beside a time-of-day counter. On every update-finished pulse from that counter it compares the current seconds, minutes and hours against three alarm values. Any alarm value whose two top bits are both 1 counts as "don't care" and matches every time value. When all three fields match, the alarm event fires.

The block also keeps a sticky flag for each of three event sources: the periodic tick, the alarm match and the update-finished pulse. Each flag is set whatever its enable says. The enables only gate the summary bit and the interrupt line. A summary bit in the flag byte, and an active-high level interrupt output, go high while any flag is set together with its enable. A host read strobe on the flag byte clears all flags on the following clock edge. An event that arrives in the same cycle as the read is kept, so that it is not lost.

The block has no state machine. Its only state is the three sticky flags. The summary bit and the interrupt output are combinational functions of those flags and the current enables.

Top module: `alarm_irq_unit`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `flags_o` reads 8'h00 and `irq_o` is 0.
- R2: A one-cycle `periodic_evt` pulse sets flag bit 6 from the next cycle, whatever `irq_en` holds.
- R3: A one-cycle `update_evt` pulse sets flag bit 4 from the next cycle, whatever `irq_en` holds.
- R4: When `update_evt` is high and all three time fields equal their alarm fields, flag bit 5 is set from the next cycle.
- R5: An alarm field whose bits 7 and 6 are both 1 matches any time value. A field with only bit 7 set is compared exactly.
- R6: Flag bit 5 is not set when any non-wildcard field differs, nor when the fields match without an `update_evt` pulse.
- R7: Flag bit 7 is 1 exactly when at least one of these pairs holds: flag bit 6 with `irq_en[2]`, flag bit 5 with `irq_en[1]`, or flag bit 4 with `irq_en[0]`. It follows a change of `irq_en` in the same cycle.
- R8: `irq_o` is active-high and level-based, and always equals flag bit 7.
- R9: A cycle with `flag_rd` high and no event clears flag bits 6..4 from the next cycle. Flags that are set stay set while no read occurs.
- R10: An event arriving in the same cycle as `flag_rd` leaves its own flag set after the clear. The other flags are cleared.
- R11: Flag bits 3..0 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_sec | input | FIELD_W | Current seconds |
| cur_min | input | FIELD_W | Current minutes |
| cur_hr | input | FIELD_W | Current hours |
| alm_sec | input | FIELD_W | Seconds alarm value |
| alm_min | input | FIELD_W | Minutes alarm value |
| alm_hr | input | FIELD_W | Hours alarm value |
| irq_en | input | 3 | Enables: [2] periodic, [1] alarm, [0] update-finished |
| periodic_evt | input | 1 | Periodic tick pulse |
| update_evt | input | 1 | Update-finished pulse, also the alarm check strobe |
| flag_rd | input | 1 | Host read of the flag byte; clears the flags |
| flags_o | output | 8 | Flag byte: [7] summary, [6] periodic, [5] alarm, [4] update |
| irq_o | output | 1 | Interrupt request, active-high level |

## Verification
The bench uses the default 8-bit field width. This makes the wildcard threshold 8'hC0, so BCD time values and the single-top-bit near miss 8'h80 can both be driven directly. With this width the bench can exercise exact matches, a mismatch in any one field, and mixed wildcard and exact alarms. It also covers enable changes while flags are held, and events that coincide with a clearing read.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
    localparam int FLAG_W  = 8;
    localparam int BIT_IRQ = 7;
    localparam int BIT_PER = 6;
    localparam int BIT_ALM = 5;
    localparam int BIT_UPD = 4;
    localparam int NUM_SRC = 3;

    typedef struct packed {
        logic per;
        logic alm;
        logic upd;
    } evt_t;
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
    parameter int FIELD_W = 8,
    parameter int WILD_W  = 2
) (
    input  logic [FIELD_W-1:0] cur,
    input  logic [FIELD_W-1:0] alm,
    output logic               match
);
    localparam logic [WILD_W-1:0] WILD_ALL = '1;

    logic wild;

    always_comb begin
        wild  = (alm[FIELD_W-1 -: WILD_W] == WILD_ALL);
        match = wild | (cur == alm);
    end
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit #(
    parameter int FIELD_W    = 8,
    parameter int NUM_FIELDS = 3
) (
    input  logic [NUM_FIELDS*FIELD_W-1:0] cur_flat,
    input  logic [NUM_FIELDS*FIELD_W-1:0] alm_flat,
    output logic                          all_match
);
    logic [NUM_FIELDS-1:0] fld_match;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        alarm_field_cmp #(
            .FIELD_W(FIELD_W),
            .WILD_W (2)
        ) i_cmp (
            .cur  (cur_flat[g*FIELD_W +: FIELD_W]),
            .alm  (alm_flat[g*FIELD_W +: FIELD_W]),
            .match(fld_match[g])
        );
    end

    assign all_match = &fld_match;
endmodule

// File: rtl/alarm_irq_flags.sv
module alarm_irq_flags
    import alarm_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  evt_t evt,
    input  evt_t en,
    input  logic rd_clr,
    output evt_t held,
    output logic irq_sum
);
    evt_t held_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (rd_clr) begin
            held_q <= evt;
        end else begin
            held_q <= held_q | evt;
        end
    end

    always_comb begin
        held    = held_q;
        irq_sum = |(held_q & en);
    end
endmodule

// File: rtl/alarm_irq_unit.sv
module alarm_irq_unit
    import alarm_irq_pkg::*;
#(
    parameter int FIELD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] cur_sec,
    input  logic [FIELD_W-1:0] cur_min,
    input  logic [FIELD_W-1:0] cur_hr,
    input  logic [FIELD_W-1:0] alm_sec,
    input  logic [FIELD_W-1:0] alm_min,
    input  logic [FIELD_W-1:0] alm_hr,
    input  logic [2:0]         irq_en,
    input  logic               periodic_evt,
    input  logic               update_evt,
    input  logic               flag_rd,
    output logic [7:0]         flags_o,
    output logic               irq_o
);
    localparam int NUM_FIELDS = 3;

    logic all_match;
    evt_t evt;
    evt_t en;
    evt_t held;
    logic irq_sum;

    alarm_match_unit #(
        .FIELD_W   (FIELD_W),
        .NUM_FIELDS(NUM_FIELDS)
    ) i_match (
        .cur_flat (  {cur_hr, cur_min, cur_sec}),
        .alm_flat (  {alm_hr, alm_min, alm_sec}),
        .all_match(all_match)
    );

    always_comb begin
        evt.per = periodic_evt;
        evt.alm = update_evt & all_match;
        evt.upd = update_evt;
        en.per  = irq_en[2];
        en.alm  = irq_en[1];
        en.upd  = irq_en[0];
    end

    alarm_irq_flags i_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt),
        .en     (en),
        .rd_clr (flag_rd),
        .held   (held),
        .irq_sum(irq_sum)
    );

    always_comb begin
        flags_o          = '0;
        flags_o[BIT_IRQ] = irq_sum;
        flags_o[BIT_PER] = held.per;
        flags_o[BIT_ALM] = held.alm;
        flags_o[BIT_UPD] = held.upd;
        irq_o            = irq_sum;
    end
endmodule

// File: rtl/alarm_irq_unit_chk.sv
module alarm_irq_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] irq_en,
    input logic       periodic_evt,
    input logic       update_evt,
    input logic       flag_rd,
    input logic [7:0] flags_o,
    input logic       irq_o
);
    AST_PER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        periodic_evt |=> flags_o[6]); // R2

    AST_UPD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        update_evt |=> flags_o[4]); // R3

    AST_ALM_NEEDS_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!update_evt && !flags_o[5]) |=> !flags_o[5]); // R6

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == 3'b000) |-> !irq_o); // R7

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && !periodic_evt && !update_evt) |=> (flags_o[6:4] == 3'b000)); // R9

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_rd && !periodic_evt && !update_evt) |=> $stable(flags_o[6:4])); // R9

    AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && periodic_evt) |=> flags_o[6]); // R10
endmodule

bind alarm_irq_unit alarm_irq_unit_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_en      (irq_en),
    .periodic_evt(periodic_evt),
    .update_evt  (update_evt),
    .flag_rd     (flag_rd),
    .flags_o     (flags_o),
    .irq_o       (irq_o)
);

// File: tb/test_alarm_irq_unit.sv
`timescale 1ns/1ps
module test_alarm_irq_unit;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [7:0] cur_sec = 0, cur_min = 0, cur_hr = 0;
    logic [7:0] alm_sec = 0, alm_min = 0, alm_hr = 0;
    logic [2:0] irq_en = 0;
    logic       periodic_evt = 0, update_evt = 0, flag_rd = 0;
    logic [7:0] flags_o;
    logic       irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // behavioural reference state
    bit m_per, m_alm, m_upd;

    always #5 clk = ~clk;

    alarm_irq_unit #(.FIELD_W(8)) i_alarm_irq_unit (
        .clk(clk), .rst_n(rst_n),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hr(cur_hr),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr),
        .irq_en(irq_en), .periodic_evt(periodic_evt), .update_evt(update_evt),
        .flag_rd(flag_rd), .flags_o(flags_o), .irq_o(irq_o)
    );

    function automatic bit fld_ok(int c, int a);
        return (a >= 192) || (a == c);
    endfunction

    function automatic logic [7:0] model_byte();
        int v;
        bit s;
        s = (m_per && irq_en[2]) || (m_alm && irq_en[1]) || (m_upd && irq_en[0]);
        v = (s ? 128 : 0) + (m_per ? 64 : 0) + (m_alm ? 32 : 0) + (m_upd ? 16 : 0);
        return 8'(v);
    endfunction

    always @(posedge clk) begin
        bit ep, ea, eu;
        if (!rst_n) begin
            m_per = 0; m_alm = 0; m_upd = 0;
        end else begin
            ep = periodic_evt;
            eu = update_evt;
            ea = update_evt && fld_ok(cur_sec, alm_sec) && fld_ok(cur_min, alm_min)
                 && fld_ok(cur_hr, alm_hr);
            if (flag_rd) begin
                m_per = ep; m_alm = ea; m_upd = eu;
            end else begin
                m_per = m_per || ep; m_alm = m_alm || ea; m_upd = m_upd || eu;
            end
        end
    end

    // per-cycle comparison against the model (R7 R8 R11)
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (flags_o !== model_byte() || irq_o !== model_byte()[7] || flags_o[3:0] !== 4'h0) begin
                failures++;
                $display("FAIL R7 R8 R11 model: flags=%h irq=%b expected flags=%h irq=%b",
                         flags_o, irq_o, model_byte(), model_byte()[7]);
            end
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic read_clear();
        flag_rd = 1; tick(); flag_rd = 0;
    endtask

    task automatic upd_pulse();
        update_evt = 1; tick(); update_evt = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick(); tick(); tick();
        chk("R1 in reset", flags_o, 8'h00);
        chk("R1 irq in reset", {7'd0, irq_o}, 8'h00);
        rst_n = 1; tick();
        chk("R1 after release", flags_o, 8'h00);

        // periodic with enable off
        periodic_evt = 1; tick(); periodic_evt = 0;
        chk("R2 periodic no enable", flags_o, 8'h40);
        chk("R8 irq low", {7'd0, irq_o}, 8'h00);
        irq_en = 3'b100; #1;
        chk("R7 enable raises summary", flags_o, 8'hC0);
        chk("R8 irq follows", {7'd0, irq_o}, 8'h01);
        tick(); tick();
        chk("R9 sticky", flags_o, 8'hC0);
        read_clear();
        chk("R9 read clears", flags_o, 8'h00);
        chk("R8 irq drops", {7'd0, irq_o}, 8'h00);

        // exact match
        cur_sec = 8'h56; cur_min = 8'h34; cur_hr = 8'h12;
        alm_sec = 8'h56; alm_min = 8'h34; alm_hr = 8'h12;
        irq_en = 3'b010;
        upd_pulse();
        chk("R4 R3 exact match", flags_o, 8'hB0);
        read_clear();

        // minute mismatch
        alm_min = 8'h35;
        upd_pulse();
        chk("R6 mismatch no alarm", flags_o, 8'h10);
        // matching values but no update pulse
        alm_min = 8'h34;
        tick(); tick();
        chk("R6 no update no alarm", flags_o, 8'h10);
        read_clear();

        // wildcard seconds and minutes
        alm_sec = 8'hC0; alm_min = 8'hFF; alm_hr = 8'h12;
        upd_pulse();
        chk("R5 wildcard match", flags_o, 8'hB0);
        read_clear();
        alm_hr = 8'h13;
        upd_pulse();
        chk("R5 exact field still compared", flags_o, 8'h10);
        read_clear();
        alm_sec = 8'h80; alm_hr = 8'h12;
        upd_pulse();
        chk("R5 single top bit not wildcard", flags_o, 8'h10);

        // event coincident with read
        irq_en = 3'b100;
        flag_rd = 1; periodic_evt = 1; tick(); flag_rd = 0; periodic_evt = 0;
        chk("R10 event kept on read", flags_o, 8'hC0);
        alm_sec = 8'h56;
        flag_rd = 1; update_evt = 1; tick(); flag_rd = 0; update_evt = 0;
        chk("R10 update and alarm kept", flags_o, 8'h30);

        irq_en = 3'b001; #1;
        chk("R7 update enable", flags_o, 8'hB0);
        irq_en = 3'b000; #1;
        chk("R7 enables off", flags_o, 8'h30);
        chk("R8 irq low", {7'd0, irq_o}, 8'h00);
        chk("R11 low bits", {4'h0, flags_o[3:0]}, 8'h00);
        tick();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule